// File: doc/BRIEF.md
# Audio Sample Serial Transmitter (Bit-Clock Slave)

This block takes a pair of 20-bit two's-complement audio samples, one for the left channel and one for the right, and shifts them out MSB first on one serial data line. It is a slave. An external controller supplies the bit clock and the frame (word-select) clock. The block oversamples both clocks in its own system clock domain. It updates the data line shortly after each bit-clock falling edge, so the receiver can capture data on the following rising edge.

A static format input chooses between two framings. In the justified framing, the word starts in the first bit period of its channel slot. In the I2S-style framing, the word starts one bit period later and the channel polarity of the frame clock is inverted. The block measures the bit-clock-to-frame ratio itself by counting bit-clock falling edges across each frame. A frame of 32 bit periods carries 16-bit words and a frame of 40 carries 20-bit words.

Samples are offered at any time on a one-cycle valid strobe and are held in a staging register. The pair in staging is committed only when a left slot begins, so both halves of a frame always come from one pair.

Top module: `audSerTx`

## Requirements
- R1: With fmtI2s = 0, lrckIn high marks the left slot and low marks the right slot. The first bit period of each slot carries sample bit 19, and the following bit periods carry the lower bits in descending order.
- R2: With fmtI2s = 1, lrckIn low marks the left slot and high marks the right slot. Sample bit 19 is carried in the second bit period of the slot. The word's last bit falls in the first bit period of the following slot.
- R3: sdOut changes only in response to a bclkIn falling edge, within four clk cycles of it. sdOut holds steady from the following bclkIn rising edge until the next falling edge.
- R4: When the last measured frame held 32 bclkIn falling edges, each slot carries 16 bits: sample bits 19 down to 4. The four low bits are dropped without rounding.
- R5: When the last measured frame held 40 bclkIn falling edges, each slot carries all 20 sample bits.
- R6: A frame is measured from one left-slot start to the next. The result governs the frame that starts at the closing boundary. After a change from 32 to 40 without reset, the first 40-edge frame still carries 16-bit words in justified framing, with 0 in its remaining bit periods. The frame after it carries 20-bit words.
- R7: The pair sent in a frame is the last pair strobed by sampleValid before that frame's left-slot start. Strobes during a frame do not change the pair sent in it, and both channels come from that one pair.
- R8: After reset, sdOut is 0 until the second left-slot start. The frame measured between the first two left-slot starts enables transmission. Bit periods that carry no word bit drive 0, including the first bit period of the first I2S-style frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| sampleL | input | 20 | Left-channel sample, two's complement |
| sampleR | input | 20 | Right-channel sample, two's complement |
| sampleValid | input | 1 | One-cycle strobe that stages sampleL and sampleR |
| bclkIn | input | 1 | Bit clock from the external controller |
| lrckIn | input | 1 | Frame clock from the external controller, selecting the channel |
| fmtI2s | input | 1 | Framing select: 0 justified, 1 I2S-style |
| sdOut | output | 1 | Serial data line |

## Verification
The bench builds the block with its package defaults: 20-bit samples and frame lengths of 32 and 40 bit periods. These defaults cover both word lengths, so truncation to 16 bits and full 20-bit words can each be checked in both framings. A receiver model rebuilds every word from sdOut on the rising bit-clock edges. That model exposes the I2S-style word that straddles a slot boundary and the zero frames before transmission is enabled. One run switches from 32 to 40 bit periods without a reset, which brings the one-frame lag of ratio adoption within reach.

// File: rtl/audSerTxPkg.sv
package audSerTxPkg;
  parameter int SAMPLE_W    = 20;
  parameter int FRAME_SHORT = 32;
  parameter int FRAME_LONG  = 40;
  localparam int IDX_W      = $clog2(FRAME_LONG);
  localparam int CNT_W      = $clog2(FRAME_LONG + 1) + 1;
  localparam int SHORT_W    = FRAME_SHORT / 2;
  localparam int LONG_W     = FRAME_LONG / 2;

  // strobes from control to datapath, valid in the cycle of a detected fall
  typedef struct packed {
    logic             fall;
    logic             slotRight;
    logic             loadPair;
    logic             txEn;
    logic             wordLong;
    logic             i2sMode;
    logic [IDX_W-1:0] bitIdx;
  } txStrobe_t;
endpackage

// File: rtl/audSerTxCtrl.sv
module audSerTxCtrl
  import audSerTxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bclkIn,
  input  logic      lrckIn,
  input  logic      fmtI2s,
  output txStrobe_t strb
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       bSync;
  logic [1:0]       lSync;
  logic             fall, lrNow, lrPrev, seenFirst;
  logic             slotStart, isLeft, leftStart, measOk;
  logic             armed, armedNext;
  logic             ratioLong, ratioLongNext;
  logic             txEn, txEnNext;
  logic [IDX_W-1:0] idxReg, idxNext;
  logic [CNT_W-1:0] frameCnt, cntNext;

  assign fall  = bSync[2] & ~bSync[1];
  assign lrNow = lSync[1];

  always_comb begin
    slotStart     = fall && seenFirst && (lrNow != lrPrev);
    isLeft        = lrNow ^ fmtI2s;
    leftStart     = slotStart && isLeft;
    measOk        = armed && (frameCnt == CNT_W'(FRAME_SHORT) ||
                              frameCnt == CNT_W'(FRAME_LONG));
    idxNext       = idxReg;
    cntNext       = frameCnt;
    armedNext     = armed;
    ratioLongNext = ratioLong;
    txEnNext      = txEn;
    if (fall) begin
      if (slotStart) idxNext = '0;
      else if (idxReg != IDX_MAX) idxNext = idxReg + IDX_W'(1);
      if (leftStart) cntNext = CNT_W'(1);
      else if (frameCnt != CNT_MAX) cntNext = frameCnt + CNT_W'(1);
    end
    if (leftStart) begin
      armedNext = 1'b1;
      if (measOk) begin
        ratioLongNext = (frameCnt == CNT_W'(FRAME_LONG));
        txEnNext      = 1'b1;
      end
    end
  end

  always_comb begin
    strb.fall      = fall;
    strb.slotRight = ~isLeft;
    strb.loadPair  = leftStart && txEnNext;
    strb.txEn      = txEnNext;
    strb.wordLong  = ratioLongNext;
    strb.i2sMode   = fmtI2s;
    strb.bitIdx    = idxNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync     <= 3'b111;
      lSync     <= 2'b00;
      lrPrev    <= 1'b0;
      seenFirst <= 1'b0;
      idxReg    <= '0;
      frameCnt  <= '0;
      armed     <= 1'b0;
      ratioLong <= 1'b0;
      txEn      <= 1'b0;
    end else begin
      bSync <= {bSync[1:0], bclkIn};
      lSync <= {lSync[0], lrckIn};
      if (fall) begin
        lrPrev    <= lrNow;
        seenFirst <= 1'b1;
      end
      idxReg    <= idxNext;
      frameCnt  <= cntNext;
      armed     <= armedNext;
      ratioLong <= ratioLongNext;
      txEn      <= txEnNext;
    end
  end

  AST_RATIO_AT_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    !leftStart |=> $stable(ratioLong)); // R6
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    txEn |=> txEn); // R8
  AST_EN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> $past(armed)); // R8
endmodule

// File: rtl/audSerTxData.sv
module audSerTxData
  import audSerTxPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sampleValid,
  input  txStrobe_t           strb,
  output logic                sdOut
);
  logic [SAMPLE_W-1:0] stageL, stageR, actL, actR;
  logic [SAMPLE_W-1:0] wordNow, shMsb, shI2s, lsbSh;
  logic [IDX_W-1:0]    wordLen;
  logic                pend, pendValid, bitNow, lastBit;

  always_comb begin
    wordLen = strb.wordLong ? IDX_W'(LONG_W) : IDX_W'(SHORT_W);
    wordNow = strb.loadPair ? stageL : (strb.slotRight ? actR : actL);
    shMsb   = wordNow << strb.bitIdx;
    shI2s   = wordNow << (strb.bitIdx - IDX_W'(1));
    lsbSh   = wordNow >> (IDX_W'(SAMPLE_W) - wordLen);
    lastBit = strb.bitIdx == (wordLen - IDX_W'(1));
    if (!strb.txEn)
      bitNow = 1'b0;
    else if (!strb.i2sMode)
      bitNow = (strb.bitIdx < wordLen) ? shMsb[SAMPLE_W-1] : 1'b0;
    else if (strb.bitIdx == '0)
      bitNow = pendValid & pend;
    else
      bitNow = (strb.bitIdx < wordLen) ? shI2s[SAMPLE_W-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageL    <= '0;
      stageR    <= '0;
      actL      <= '0;
      actR      <= '0;
      pend      <= 1'b0;
      pendValid <= 1'b0;
      sdOut     <= 1'b0;
    end else begin
      if (sampleValid) begin
        stageL <= sampleL;
        stageR <= sampleR;
      end
      if (strb.fall) begin
        if (strb.loadPair) begin
          actL <= stageL;
          actR <= stageR;
        end
        sdOut <= bitNow;
        if (!strb.txEn) pendValid <= 1'b0;
        else if (strb.i2sMode && lastBit) begin
          pend      <= lsbSh[0];
          pendValid <= 1'b1;
        end
      end
    end
  end

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fall |=> $stable(sdOut)); // R3
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txEn |-> !sdOut); // R8
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fall && strb.loadPair) |=> $stable(actL) && $stable(actR)); // R7
endmodule

// File: rtl/audSerTx.sv
module audSerTx
  import audSerTxPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sampleValid,
  input  logic                bclkIn,
  input  logic                lrckIn,
  input  logic                fmtI2s,
  output logic                sdOut
);
  txStrobe_t strb;

  audSerTxCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .bclkIn (bclkIn),
    .lrckIn (lrckIn),
    .fmtI2s (fmtI2s),
    .strb   (strb)
  );

  audSerTxData data_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleL     (sampleL),
    .sampleR     (sampleR),
    .sampleValid (sampleValid),
    .strb        (strb),
    .sdOut       (sdOut)
  );
endmodule

// File: tb/audSerTx_tb_top.sv
`timescale 1ns/1ps
module audSerTx_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] sampleL = '0, sampleR = '0;
  logic        sampleValid = 1'b0;
  logic        bclkIn = 1'b1, lrckIn = 1'b0, fmtI2s = 1'b0;
  logic        sdOut;

  audSerTx dut_i (
    .clk(clk), .rstN(rstN), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .bclkIn(bclkIn), .lrckIn(lrckIn),
    .fmtI2s(fmtI2s), .sdOut(sdOut)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          frame;
    logic [19:0] l;
    logic [19:0] r;
    string       tag;
  } item_t;
  item_t q[$];

  int nChecks = 0, nFails = 0;
  int drvBit = 0, drvN = 32, drvFrame = 0, zeroBelow = 2, stableErr = 0;
  bit drvFmt = 1'b0, monOn = 1'b0, riseSeen = 1'b0, done = 1'b0;
  logic riseVal = 1'b0;
  logic [19:0] rx [2];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkPair(input int f);
    if (f >= 0) begin
      if (f < zeroBelow)
        check({rx[0], rx[1]} == 40'h0, "R8", $sformatf("frame %0d before enable", f),
              {rx[0], rx[1]}, 40'h0);
      else if (q.size() > 0 && q[0].frame == f) begin
        item_t it = q.pop_front();
        check({rx[0], rx[1]} == {it.l, it.r}, {it.tag, "/R7"},
              $sformatf("frame %0d pair", f), {rx[0], rx[1]}, {it.l, it.r});
      end
    end
    rx[0] = '0;
    rx[1] = '0;
  endtask

  // monitor: receiver model capturing on the rising bit-clock edge
  always @(posedge bclkIn) begin
    if (monOn) begin
      int slot, ch, p;
      slot = drvN / 2;
      ch = (drvBit >= slot) ? 1 : 0;
      p = drvBit % slot;
      riseVal = sdOut;
      riseSeen = 1'b1;
      if (!drvFmt) begin
        rx[ch][19-p] = sdOut;
        if (ch == 1 && p == slot - 1) checkPair(drvFrame);
      end else if (p == 0) begin
        rx[1-ch][20-slot] = sdOut;
        if (ch == 0) checkPair(drvFrame - 1);
      end else begin
        rx[ch][20-p] = sdOut;
      end
    end
  end

  function automatic logic [19:0] trunc(input logic [19:0] v, input int w);
    return (w == 16) ? {v[19:4], 4'h0} : v;
  endfunction

  task automatic runFrames(input bit fmt, input int nBits, input int nFrames,
                           input bit doReset, input bit lastRun, input string tag);
    if (doReset) begin
      monOn = 1'b0;
      rstN = 1'b0;
      bclkIn = 1'b1;
      fmtI2s = fmt;
      lrckIn = fmt;
      q.delete();
      rx[0] = '0;
      rx[1] = '0;
      riseSeen = 1'b0;
      drvFrame = 0;
      zeroBelow = 2;
      repeat (10) @(negedge clk);
      rstN = 1'b1;
      repeat (5) @(negedge clk);
      check(sdOut == 1'b0, "R8", "output after reset", {39'h0, sdOut}, 40'h0);
      monOn = 1'b1;
    end
    drvFmt = fmt;
    for (int k = 0; k < nFrames; k++) begin
      for (int b = 0; b < nBits; b++) begin
        @(negedge clk);
        if (riseSeen && sdOut !== riseVal) stableErr++;
        riseSeen = 1'b0;
        drvBit = b;
        drvN = nBits;
        bclkIn = 1'b0;
        lrckIn = (b < nBits / 2) ? ~fmt : fmt;
        if (b == 3) begin
          sampleL = 20'($urandom());
          sampleR = 20'($urandom());
          sampleValid = 1'b1;
        end
        if (b == nBits / 2 + 5) begin
          if (drvFrame + 1 == zeroBelow) begin
            sampleL = 20'h7FFFF;
            sampleR = 20'h80000;
          end else begin
            sampleL = 20'($urandom());
            sampleR = 20'($urandom());
          end
          sampleValid = 1'b1;
          if ((drvFrame + 1 >= zeroBelow) && (!lastRun || k + 2 < nFrames)) begin
            item_t it;
            it.frame = drvFrame + 1;
            it.l = trunc(sampleL, nBits / 2);
            it.r = trunc(sampleR, nBits / 2);
            it.tag = tag;
            q.push_back(it);
          end
        end
        @(negedge clk);
        sampleValid = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        bclkIn = 1'b1;
        repeat (HALF - 1) @(negedge clk);
      end
      drvFrame++;
    end
    check(stableErr == 0, "R3", "sdOut moved outside falling edge",
          40'(stableErr), 40'h0);
    stableErr = 0;
    if (lastRun)
      check(q.size() == 0, "R7", "pairs left undelivered", 40'(q.size()), 40'h0);
  endtask

  initial begin
    rx[0] = '0;
    rx[1] = '0;
    runFrames(1'b0, 32, 6, 1'b1, 1'b1, "R1/R4");
    runFrames(1'b0, 40, 6, 1'b1, 1'b1, "R1/R5");
    runFrames(1'b1, 32, 6, 1'b1, 1'b1, "R2/R4");
    runFrames(1'b1, 40, 6, 1'b1, 1'b1, "R2/R5");
    runFrames(1'b0, 32, 6, 1'b1, 1'b0, "R6/R4");
    runFrames(1'b0, 40, 5, 1'b0, 1'b1, "R6/R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule